// File: doc/BRIEF.md
# DPLL Mode Supervisor with Lock Status

This block is the supervisory state machine that sits beside a clock-rate-conversion DPLL. It decides whether the digitally controlled oscillator runs from the master clock alone (Freerun) or follows the input reference (Normal). It holds the clock outputs in high impedance for a stretched interval after reset. It also drives a lock status pin that qualifies phase lock over time and rides through short reference outages.

Two status inputs come from the neighbouring logic: a reference-fail flag from the reference monitor and a phase-in-window flag from the phase detector. Both pass through a two-flop synchronizer before use. All three time intervals are parameters counted in master-clock cycles: the reset stretch, the lock qualification time and the lock hold-off time.

Top module: `dpll_mode_ctrl`

## Requirements
- R1: While rst_n is low, mode_o is Reset (code 2'b00), out_en_o is 0 and lock_o is 0, without waiting for a clock edge. After rst_n rises, mode_o stays at Reset for exactly RST_CYC rising edges.
- R2: out_en_o is 0 exactly while mode_o is Reset, and 1 in every other mode.
- R3: When the Reset interval ends, mode_o becomes Freerun (code 2'b01) whatever the level of ref_fail_i.
- R4: From Freerun, mode_o moves to Normal (code 2'b10) when the synchronized reference-fail flag is low. From Normal, it moves back to Freerun when that flag is high. A change on ref_fail_i shows on mode_o after the third rising edge that samples the new level.
- R5: lock_o rises only in Normal, after the synchronized in-window flag has been high for QUAL_CYC consecutive Normal cycles.
- R6: If the synchronized in-window flag is low during a Normal cycle, lock_o is low after the next edge and qualification starts again from zero.
- R7: When Normal falls back to Freerun with lock_o high, lock_o stays high for HOLD_CYC Freerun cycles and then falls. If Normal returns before that, lock_o stays high without a gap.
- R8: lock_o stays low through a Freerun period that was not entered from a locked Normal state, for example the first Freerun after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_fail_i | input | 1 | Reference failure flag from the reference monitor (asynchronous) |
| in_window_i | input | 1 | Phase error inside the lock window (asynchronous) |
| mode_o | output | 2 | Current mode: 00 Reset, 01 Freerun, 10 Normal |
| out_en_o | output | 1 | Output-enable for the clock output drivers |
| lock_o | output | 1 | Lock status |

## Verification
Two events can land on the same edge: the hold-off counter expiring and the mode switching back to Normal. The bench provokes this with a reference-fail pulse exactly HOLD_CYC cycles long and compares it with a pulse one cycle shorter. The expected result is that lock drops at that edge in the first case and survives in the second. A second collision is a drop of the in-window flag in the same cycle that qualification would complete. A behavioural model in the bench settles all of these cases, and its outputs are compared with the design on every cycle.

// File: rtl/dpll_mode_pkg.sv
package dpll_mode_pkg;

  typedef enum logic [1:0] {
    M_RST  = 2'b00,
    M_FREE = 2'b01,
    M_NORM = 2'b10
  } mode_t;

  // saturating increment toward a limit
  function automatic int unsigned sat_inc(input int unsigned v, input int unsigned lim);
    return (v >= lim) ? lim : v + 1;
  endfunction

  // width needed to hold the value n
  function automatic int unsigned cnt_w(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

endpackage

// File: rtl/dpll_sync2.sv
module dpll_sync2 #(
  parameter int WIDTH = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic s1, s2;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1 <= 1'b0;
        s2 <= 1'b0;
      end else begin
        s1 <= d_i[b];
        s2 <= s1;
      end
    end
    assign q_o[b] = s2;
  end
endmodule

// File: rtl/dpll_mode_fsm.sv
module dpll_mode_fsm
  import dpll_mode_pkg::*;
#(
  parameter int unsigned RST_CYC = 150000
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  ref_fail_s,
  output mode_t mode,
  output logic  out_en
);
  localparam int unsigned RW = cnt_w(RST_CYC);

  logic [RW-1:0] rcnt;
  logic          stretch_done;

  assign stretch_done = (rcnt == RW'(RST_CYC - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode <= M_RST;
      rcnt <= '0;
    end else begin
      unique case (mode)
        M_RST: begin
          rcnt <= RW'(sat_inc(rcnt, RST_CYC));
          if (stretch_done) mode <= M_FREE;
        end
        M_FREE: if (!ref_fail_s) mode <= M_NORM;
        M_NORM: if (ref_fail_s) mode <= M_FREE;
        default: mode <= M_RST;
      endcase
    end
  end

  assign out_en = (mode != M_RST);

  // R3: the reset stretch only ever exits to Freerun
  p_reset_exit_free_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mode == M_RST |=> (mode == M_RST || mode == M_FREE));
  // R4: a failed reference holds Freerun
  p_free_hold_on_fail_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_FREE && ref_fail_s) |=> mode == M_FREE);
  // R4: a failed reference ends Normal
  p_norm_exit_on_fail_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_NORM && ref_fail_s) |=> mode == M_FREE);
endmodule

// File: rtl/dpll_lock_ctrl.sv
module dpll_lock_ctrl
  import dpll_mode_pkg::*;
#(
  parameter int unsigned QUAL_CYC = 50000,
  parameter int unsigned HOLD_CYC = 5000000
) (
  input  logic  clk,
  input  logic  rst_n,
  input  mode_t mode,
  input  logic  in_win_s,
  output logic  lock
);
  localparam int unsigned QW = cnt_w(QUAL_CYC);
  localparam int unsigned HW = cnt_w(HOLD_CYC);

  logic [QW-1:0] qcnt;
  logic [HW-1:0] hcnt;
  logic          qual_hit;
  logic          hold_expire;

  assign qual_hit    = (qcnt >= QW'(QUAL_CYC - 1));
  assign hold_expire = (hcnt == HW'(HOLD_CYC - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock <= 1'b0;
      qcnt <= '0;
      hcnt <= '0;
    end else begin
      unique case (mode)
        M_NORM: begin
          hcnt <= '0;
          if (!in_win_s) begin
            qcnt <= '0;
            lock <= 1'b0;
          end else begin
            qcnt <= QW'(sat_inc(qcnt, QUAL_CYC));
            if (qual_hit) lock <= 1'b1;
          end
        end
        M_FREE: begin
          if (lock) begin
            if (hold_expire) begin
              lock <= 1'b0;
              hcnt <= '0;
              qcnt <= '0;
            end else begin
              hcnt <= HW'(sat_inc(hcnt, HOLD_CYC));
            end
          end else begin
            hcnt <= '0;
            qcnt <= '0;
          end
        end
        default: begin
          lock <= 1'b0;
          qcnt <= '0;
          hcnt <= '0;
        end
      endcase
    end
  end

  // R1: no lock while the reset stretch runs
  p_no_lock_in_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
    mode == M_RST |-> !lock);
  // R5: lock only rises out of a Normal cycle
  p_lock_rise_norm_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != M_NORM && !lock) |=> !lock);
  // R6: a window drop in Normal clears lock
  p_win_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_NORM && !in_win_s) |=> !lock);
  // R7: lock stays up in Freerun until the hold-off counter ends
  p_hold_keeps_lock_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_FREE && lock && !hold_expire) |=> lock);
endmodule

// File: rtl/dpll_mode_ctrl.sv
module dpll_mode_ctrl
  import dpll_mode_pkg::*;
#(
  parameter int unsigned RST_CYC  = 150000,
  parameter int unsigned QUAL_CYC = 50000,
  parameter int unsigned HOLD_CYC = 5000000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ref_fail_i,
  input  logic       in_window_i,
  output logic [1:0] mode_o,
  output logic       out_en_o,
  output logic       lock_o
);
  logic [1:0] sync_q;
  logic       ref_fail_s;
  logic       in_win_s;
  mode_t      mode;

  dpll_sync2 #(.WIDTH(2)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   ({in_window_i, ref_fail_i}),
    .q_o   (sync_q)
  );

  assign ref_fail_s = sync_q[0];
  assign in_win_s   = sync_q[1];

  dpll_mode_fsm #(.RST_CYC(RST_CYC)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .ref_fail_s (ref_fail_s),
    .mode       (mode),
    .out_en     (out_en_o)
  );

  dpll_lock_ctrl #(.QUAL_CYC(QUAL_CYC), .HOLD_CYC(HOLD_CYC)) u_lock (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode     (mode),
    .in_win_s (in_win_s),
    .lock     (lock_o)
  );

  assign mode_o = mode;

  // R2: output drivers are enabled exactly outside the reset stretch
  p_oe_vs_mode_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_en_o == (mode_o != 2'b00));
endmodule

// File: tb/dpll_mode_ctrl_tb.sv
module dpll_mode_ctrl_tb;
  localparam int RST_C  = 8;
  localparam int QUAL_C = 6;
  localparam int HOLD_C = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ref_fail_i = 1'b0;
  logic       in_window_i = 1'b0;
  logic [1:0] mode_o;
  logic       out_en_o;
  logic       lock_o;

  int n_chk = 0;
  int n_fail = 0;
  string tag = "R1";
  bit done = 1'b0;

  always #10 clk = ~clk;

  dpll_mode_ctrl #(.RST_CYC(RST_C), .QUAL_CYC(QUAL_C), .HOLD_CYC(HOLD_C)) u_dut (
    .clk(clk), .rst_n(rst_n), .ref_fail_i(ref_fail_i), .in_window_i(in_window_i),
    .mode_o(mode_o), .out_en_o(out_en_o), .lock_o(lock_o)
  );

  // behavioural reference: 0 reset, 1 freerun, 2 normal
  int m_mode, m_rc, m_q, m_h;
  bit m_lock;
  bit rh[2];
  bit wh[2];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode = 0; m_rc = 0; m_q = 0; m_h = 0; m_lock = 0;
      rh = '{0, 0}; wh = '{0, 0};
    end else begin
      bit r, w;
      r = rh[1]; w = wh[1];
      rh[1] = rh[0]; rh[0] = ref_fail_i;
      wh[1] = wh[0]; wh[0] = in_window_i;
      if (m_mode == 2) begin
        m_h = 0;
        if (!w) begin m_q = 0; m_lock = 0; end
        else begin
          if (m_q < QUAL_C) m_q++;
          if (m_q >= QUAL_C) m_lock = 1;
        end
      end else if (m_mode == 1) begin
        if (m_lock) begin
          m_h++;
          if (m_h >= HOLD_C) begin m_lock = 0; m_h = 0; m_q = 0; end
        end else begin m_h = 0; m_q = 0; end
      end else begin
        m_lock = 0; m_q = 0; m_h = 0;
      end
      if (m_mode == 0) begin
        m_rc++;
        if (m_rc >= RST_C) m_mode = 1;
      end else if (m_mode == 1) begin
        if (!r) m_mode = 2;
      end else if (r) m_mode = 1;
    end
  end

  task automatic chk(input bit ok, input string t, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", t, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      chk(mode_o == 2'(m_mode), {tag, " mode"}, int'(mode_o), m_mode);
      chk(out_en_o == (m_mode != 0), "R2 out_en", int'(out_en_o), int'(m_mode != 0));
      chk(lock_o == m_lock, {tag, " lock"}, int'(lock_o), int'(m_lock));
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    int wd = 0;
    while (!done) begin
      @(posedge clk);
      wd++;
      if (wd > 20000) begin
        n_fail++;
        $display("FAIL watchdog actual=%0d expected<=%0d", wd, 20000);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
      end
    end
  end

  initial begin
    // R1 reset values
    ref_fail_i = 1'b0; in_window_i = 1'b1;
    cyc(3);
    chk(mode_o == 2'b00 && !out_en_o && !lock_o, "R1 reset state", int'(mode_o), 0);
    rst_n = 1'b1;
    tag = "R1"; cyc(RST_C - 1);
    chk(mode_o == 2'b00, "R1 stretch still on", int'(mode_o), 0);
    tag = "R3"; cyc(2);
    tag = "R8"; cyc(2);
    tag = "R5"; cyc(QUAL_C + 6);
    chk(lock_o == 1'b1, "R5 locked", int'(lock_o), 1);
    // short outage: lock holds
    tag = "R7"; ref_fail_i = 1'b1; cyc(4); ref_fail_i = 1'b0; cyc(8);
    chk(lock_o == 1'b1, "R7 lock rides short outage", int'(lock_o), 1);
    // outage of HOLD_C-1 cycles: lock survives
    ref_fail_i = 1'b1; cyc(HOLD_C - 1); ref_fail_i = 1'b0; cyc(6);
    // outage of exactly HOLD_C: expiry collides with return to Normal
    ref_fail_i = 1'b1; cyc(HOLD_C); ref_fail_i = 1'b0; cyc(QUAL_C + 6);
    // window drop and requalify
    tag = "R6"; in_window_i = 1'b0; cyc(1); in_window_i = 1'b1; cyc(4);
    chk(lock_o == 1'b0, "R6 lock cleared", int'(lock_o), 0);
    cyc(QUAL_C);
    // window drop on the qualifying cycle
    in_window_i = 1'b0; cyc(2); in_window_i = 1'b1; cyc(QUAL_C - 1);
    in_window_i = 1'b0; cyc(1); in_window_i = 1'b1; cyc(QUAL_C + 5);
    // long outage: lock falls after hold-off
    tag = "R7"; ref_fail_i = 1'b1; cyc(HOLD_C + 8);
    chk(lock_o == 1'b0 && mode_o == 2'b01, "R7 lock fell in Freerun", int'(lock_o), 0);
    tag = "R4"; ref_fail_i = 1'b0; cyc(3);
    chk(mode_o == 2'b10, "R4 back to Normal", int'(mode_o), 2);
    tag = "R8"; in_window_i = 1'b0; ref_fail_i = 1'b1; cyc(6);
    in_window_i = 1'b1; cyc(6);
    // async reset mid-cycle, reference failed across release
    #3 rst_n = 1'b0; #1;
    chk(mode_o == 2'b00 && !lock_o && !out_en_o, "R1 async reset", int'(mode_o), 0);
    tag = "R1"; cyc(2); rst_n = 1'b1;
    tag = "R3"; cyc(RST_C + 6);
    chk(mode_o == 2'b01, "R3 Freerun despite fail", int'(mode_o), 1);
    tag = "R8"; cyc(4);
    chk(lock_o == 1'b0, "R8 no lock after reset", int'(lock_o), 0);
    tag = "R4"; ref_fail_i = 1'b0; cyc(2);
    chk(mode_o == 2'b01, "R4 sync delay", int'(mode_o), 1);
    cyc(1);
    chk(mode_o == 2'b10, "R4 Normal after sync", int'(mode_o), 2);
    tag = "R5"; cyc(QUAL_C + 4);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule